// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the byte-wide host side of a fixed-disk controller for an 8-bit expansion bus. The host reaches it through four register offsets. A write to the select offset opens a command phase. The host then writes a six-byte command block, one byte at a time, through the data offset. When the last byte arrives, the block raises a one-cycle `cmd_ready` pulse to a command executor and holds the busy state until that executor answers.

The executor owns the media and the command semantics. It can ask the block to collect a data phase from the host (`ex_rx_go`) or to hand a data phase to the host (`ex_tx_go`). Both directions share one byte buffer, and the executor reaches that buffer through its own port. The executor ends a command with `ex_done`. The block then builds a completion byte and raises the interrupt if the host enabled it. The command ends when the host reads that byte back through the data offset, which also returns the block to idle. The status byte uses a REQ/IO/CD/BSY handshake, so the host's driver can tell which phase is under way.

Top module: `xt_disk_host_if`

## Requirements
- R1: After `rst_n` is released, `irq` is low, the status byte reads 0x00 and the block is idle.
- R2: A write to offset 2 restarts the byte count, expects six command bytes and makes status read 0x0D (BSY bit 3, CD bit 2, REQ bit 0).
- R3: While receiving, each write to offset 0 stores the byte at the next buffer position, counting from 0. After the last expected byte, REQ and CD clear. A command block then pulses `cmd_ready` and latches `drive_sel` from bit 5 of its second byte. A data phase pulses `rx_done` instead.
- R4: A write to offset 0 is rejected when the block is not receiving, including after the buffer is full. A rejected write stores nothing, sets `sense_code` to 0x20 and marks the pending completion byte as failed.
- R5: `ex_tx_go` sets IO and REQ (status 0x0B). Reads of offset 0 then return buffer bytes in order from position 0. After the last byte, REQ clears (status 0x0A) and `tx_done` pulses.
- R6: The `ex_len` value given with `ex_rx_go` or `ex_tx_go` is clamped to the range 1 to BUF_DEPTH.
- R7: `ex_done` makes the low status nibble 0xF. The completion byte carries bit 5 for drive 1 and bit 1 when `ex_err` was set or a write was rejected since the last select. With `ex_err` set, `sense_code` takes `ex_sense`.
- R8: Status bit 5 and `irq` are set at completion only when mask bit 1 is set. Any read of offset 0 clears them. Reads of the other offsets leave them unchanged.
- R9: In the complete state, a read of offset 0 returns the completion byte, clears status to 0x00 and returns the block to idle.
- R10: A write to offset 1 clears `sense_code` and status, and puts the block back to idle.
- R11: A read of offset 1 returns status with bit 7 forced to 0. Offsets 2 and 3 read 0xFF. Offset 0 reads 0xFF outside the send and complete states.
- R12: Bit 0 of the mask register, written at offset 3, drives `dma_en`.
- R13: `ex_done`, `ex_rx_go` and `ex_tx_go` are ignored unless the block is waiting on the executor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while `host_rd` is high |
| irq | output | 1 | Level interrupt request |
| dma_en | output | 1 | Mask bit 0 |
| cmd_ready | output | 1 | Pulse: command block received |
| drive_sel | output | 1 | Drive addressed by the command block |
| rx_done | output | 1 | Pulse: host-to-buffer data phase done |
| tx_done | output | 1 | Pulse: buffer-to-host data phase done |
| sense_code | output | 8 | Current sense code |
| ex_len | input | clog2(BUF_DEPTH+1) | Byte count for the next data phase |
| ex_rx_go | input | 1 | Executor asks for a host-to-buffer phase |
| ex_tx_go | input | 1 | Executor asks for a buffer-to-host phase |
| ex_done | input | 1 | Executor finished the command |
| ex_err | input | 1 | Command failed, sampled with `ex_done` |
| ex_sense | input | 8 | Sense code to load on failure |
| ex_buf_we | input | 1 | Executor buffer write enable |
| ex_buf_addr | input | clog2(BUF_DEPTH) | Executor buffer address |
| ex_buf_wdata | input | 8 | Executor buffer write data |
| ex_buf_rdata | output | 8 | Executor buffer read data |

## Verification
The bench builds the block with BUF_DEPTH set to 8. At that depth the six-byte command block still fits, with two positions to spare. A request for 15 bytes is clamped to the full buffer after only eight writes. A value preloaded in a spare position shows that a rejected write past the command block leaves storage alone. The small depth therefore reaches the clamp boundary and the full-buffer rejection within a few bus cycles. It also walks every handshake phase: command, receive, send, completion with and without the interrupt, host reset in mid-command, and executor pulses arriving out of turn.

// File: rtl/xhc_pkg.sv
package xhc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RECV  = 3'd1,
    ST_EXEC  = 3'd2,
    ST_SEND  = 3'd3,
    ST_COMPL = 3'd4
  } xhc_state_e;

  localparam int STB_REQ = 0;
  localparam int STB_IO  = 1;
  localparam int STB_CD  = 2;
  localparam int STB_BSY = 3;
  localparam int STB_IRQ = 5;
  localparam int STB_ACC = 7;

  localparam logic [7:0] STATUS_SELECT = 8'h0D;
  localparam logic [7:0] SENSE_BAD_CMD = 8'h20;
  localparam int         CMD_BLOCK_LEN = 6;

  // Clamp a requested phase length into 1..depth.
  function automatic int fit_len(input int req, input int depth);
    if (req < 1) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

  // True when the byte at position pos closes a phase of total bytes.
  function automatic logic at_last(input int pos, input int total);
    return (pos + 1) == total;
  endfunction

  // Completion byte: drive flag on bit 5, failure flag on bit 1.
  function automatic logic [7:0] comp_byte(input logic drv, input logic err);
    return {2'b00, drv, 3'b000, err, 1'b0};
  endfunction

  // Status after completion, interrupt bit only when enabled.
  function automatic logic [7:0] done_status(input logic irq_en);
    return 8'h0F | (irq_en ? 8'h20 : 8'h00);
  endfunction

  // Host view of status: the accepted-block flag never shows.
  function automatic logic [7:0] status_view(input logic [7:0] s);
    return {1'b0, s[6:0]};
  endfunction

endpackage

// File: rtl/xhc_buffer.sv
module xhc_buffer #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          x_we,
  input  logic [AW-1:0] x_addr,
  input  logic [7:0]    x_wdata,
  output logic [7:0]    x_rdata
);

  logic [7:0] mem [DEPTH];

  // Host stores win over executor stores in the same cycle.
  always_ff @(posedge clk) begin
    if (h_we)      mem[h_addr] <= h_wdata;
    else if (x_we) mem[x_addr] <= x_wdata;
  end

  assign h_rdata = mem[h_addr];
  assign x_rdata = mem[x_addr];

endmodule

// File: rtl/xhc_seq.sv
module xhc_seq
  import xhc_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int AW        = 4,
  parameter int LEN_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  input  logic [LEN_W-1:0] ex_len,
  input  logic             ex_rx_go,
  input  logic             ex_tx_go,
  input  logic             ex_done,
  input  logic             ex_err,
  input  logic [7:0]       ex_sense,
  output xhc_state_e       state_q,
  output logic [7:0]       status_q,
  output logic [7:0]       comp_q,
  output logic [7:0]       sense_q,
  output logic             dma_en_q,
  output logic             drive_q,
  output logic [AW-1:0]    buf_addr,
  output logic             store_ok,
  output logic             reject_now,
  output logic             cmd_ready_q,
  output logic             rx_done_q,
  output logic             tx_done_q,
  output logic             complete_q
);

  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic             irq_en_q;
  logic             comp_err_q;
  logic             data_wr;
  logic             data_rd;
  logic             idx_last;
  logic [LEN_W-1:0] ex_len_fit;

  assign data_wr    = host_wr && (host_addr == 2'd0);
  assign data_rd    = host_rd && (host_addr == 2'd0);
  assign store_ok   = data_wr && (state_q == ST_RECV) && status_q[STB_REQ] && (idx_q < len_q);
  assign reject_now = data_wr && !store_ok;
  assign idx_last   = at_last(int'(idx_q), int'(len_q));
  assign ex_len_fit = LEN_W'(fit_len(int'(ex_len), BUF_DEPTH));
  assign buf_addr   = idx_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      status_q    <= 8'h00;
      comp_q      <= 8'h00;
      sense_q     <= 8'h00;
      dma_en_q    <= 1'b0;
      irq_en_q    <= 1'b0;
      drive_q     <= 1'b0;
      idx_q       <= '0;
      len_q       <= '0;
      comp_err_q  <= 1'b0;
      cmd_ready_q <= 1'b0;
      rx_done_q   <= 1'b0;
      tx_done_q   <= 1'b0;
      complete_q  <= 1'b0;
    end else begin
      cmd_ready_q <= 1'b0;
      rx_done_q   <= 1'b0;
      tx_done_q   <= 1'b0;
      complete_q  <= 1'b0;

      if (host_wr && host_addr == 2'd3) begin
        dma_en_q <= host_wdata[0];
        irq_en_q <= host_wdata[1];
      end

      if (host_wr && host_addr == 2'd1) begin
        sense_q  <= 8'h00;
        status_q <= 8'h00;
        state_q  <= ST_IDLE;
      end else if (host_wr && host_addr == 2'd2) begin
        idx_q      <= '0;
        len_q      <= LEN_W'(CMD_BLOCK_LEN);
        state_q    <= ST_RECV;
        status_q   <= STATUS_SELECT;
        comp_err_q <= 1'b0;
      end else begin
        // Executor side: only heard while waiting on it.
        if (state_q == ST_EXEC) begin
          if (ex_done) begin
            comp_q     <= comp_byte(drive_q, ex_err | comp_err_q);
            if (ex_err) sense_q <= ex_sense;
            status_q   <= done_status(irq_en_q);
            state_q    <= ST_COMPL;
            complete_q <= 1'b1;
          end else if (ex_rx_go) begin
            idx_q    <= '0;
            len_q    <= ex_len_fit;
            status_q <= 8'h00;
            status_q[STB_BSY] <= 1'b1;
            status_q[STB_ACC] <= 1'b1;
            status_q[STB_REQ] <= 1'b1;
            state_q  <= ST_RECV;
          end else if (ex_tx_go) begin
            idx_q    <= '0;
            len_q    <= ex_len_fit;
            status_q <= 8'h00;
            status_q[STB_BSY] <= 1'b1;
            status_q[STB_ACC] <= 1'b1;
            status_q[STB_IO]  <= 1'b1;
            status_q[STB_REQ] <= 1'b1;
            state_q  <= ST_SEND;
          end
        end

        // Host data writes.
        if (store_ok) begin
          idx_q <= idx_q + LEN_W'(1);
          if (!status_q[STB_ACC] && idx_q == LEN_W'(1)) drive_q <= host_wdata[5];
          if (idx_last) begin
            status_q[STB_REQ] <= 1'b0;
            status_q[STB_CD]  <= 1'b0;
            state_q           <= ST_EXEC;
            if (status_q[STB_ACC]) begin
              rx_done_q <= 1'b1;
            end else begin
              status_q[STB_ACC] <= 1'b1;
              cmd_ready_q       <= 1'b1;
            end
          end
        end
        if (reject_now) begin
          comp_err_q <= 1'b1;
          sense_q    <= SENSE_BAD_CMD;
        end

        // Host data reads.
        if (data_rd) begin
          if (state_q == ST_SEND) begin
            idx_q <= idx_q + LEN_W'(1);
            if (idx_last) begin
              status_q[STB_REQ] <= 1'b0;
              tx_done_q         <= 1'b1;
              state_q           <= ST_EXEC;
            end
          end else if (state_q == ST_COMPL) begin
            status_q <= 8'h00;
            state_q  <= ST_IDLE;
          end
          status_q[STB_IRQ] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/xhc_rdmux.sv
module xhc_rdmux
  import xhc_pkg::*;
(
  input  logic [1:0] host_addr,
  input  xhc_state_e state_q,
  input  logic [7:0] status_q,
  input  logic [7:0] comp_q,
  input  logic [7:0] buf_byte,
  output logic [7:0] host_rdata
);

  always_comb begin
    host_rdata = 8'hFF;
    unique case (host_addr)
      2'd0: begin
        if (state_q == ST_SEND)       host_rdata = buf_byte;
        else if (state_q == ST_COMPL) host_rdata = comp_q;
      end
      2'd1:    host_rdata = status_view(status_q);
      default: host_rdata = 8'hFF;
    endcase
  end

endmodule

// File: rtl/xt_disk_host_if.sv
module xt_disk_host_if
  import xhc_pkg::*;
#(
  parameter  int BUF_DEPTH = 16,
  localparam int AW        = $clog2(BUF_DEPTH),
  localparam int LEN_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             irq,
  output logic             dma_en,
  output logic             cmd_ready,
  output logic             drive_sel,
  output logic             rx_done,
  output logic             tx_done,
  output logic [7:0]       sense_code,
  input  logic [LEN_W-1:0] ex_len,
  input  logic             ex_rx_go,
  input  logic             ex_tx_go,
  input  logic             ex_done,
  input  logic             ex_err,
  input  logic [7:0]       ex_sense,
  input  logic             ex_buf_we,
  input  logic [AW-1:0]    ex_buf_addr,
  input  logic [7:0]       ex_buf_wdata,
  output logic [7:0]       ex_buf_rdata
);

  xhc_state_e    state_q;
  logic [7:0]    status_q;
  logic [7:0]    comp_q;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_byte;
  logic          store_ok;
  logic          reject_now;
  logic          complete_q;

  xhc_seq #(.BUF_DEPTH(BUF_DEPTH), .AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .ex_len     (ex_len),
    .ex_rx_go   (ex_rx_go),
    .ex_tx_go   (ex_tx_go),
    .ex_done    (ex_done),
    .ex_err     (ex_err),
    .ex_sense   (ex_sense),
    .state_q    (state_q),
    .status_q   (status_q),
    .comp_q     (comp_q),
    .sense_q    (sense_code),
    .dma_en_q   (dma_en),
    .drive_q    (drive_sel),
    .buf_addr   (buf_addr),
    .store_ok   (store_ok),
    .reject_now (reject_now),
    .cmd_ready_q(cmd_ready),
    .rx_done_q  (rx_done),
    .tx_done_q  (tx_done),
    .complete_q (complete_q)
  );

  xhc_buffer #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk    (clk),
    .h_we   (store_ok),
    .h_addr (buf_addr),
    .h_wdata(host_wdata),
    .h_rdata(buf_byte),
    .x_we   (ex_buf_we),
    .x_addr (ex_buf_addr),
    .x_wdata(ex_buf_wdata),
    .x_rdata(ex_buf_rdata)
  );

  xhc_rdmux u_rdmux (
    .host_addr (host_addr),
    .state_q   (state_q),
    .status_q  (status_q),
    .comp_q    (comp_q),
    .buf_byte  (buf_byte),
    .host_rdata(host_rdata)
  );

  assign irq = status_q[STB_IRQ];

endmodule

// File: rtl/xhc_checker.sv
module xhc_checker
  import xhc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] host_addr,
  input logic       host_wr,
  input logic       host_rd,
  input logic [7:0] host_rdata,
  input logic       irq,
  input logic [7:0] status_q,
  input xhc_state_e state_q,
  input logic [7:0] sense_code,
  input logic       ev_reject,
  input logic       ev_cmd_ready,
  input logic       ev_rx_done,
  input logic       ev_tx_done,
  input logic       ev_complete
);

  a_r2_select_status: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd2 |=> status_q == 8'h0D);

  a_r3_cmd_waits_executor: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_ready |-> (state_q == ST_EXEC) && !status_q[0]);

  a_r3_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd_ready, ev_rx_done, ev_tx_done, ev_complete}));

  a_r4_reject_sense: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> sense_code == 8'h20);

  a_r7_complete_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    ev_complete |-> status_q[3:0] == 4'hF);

  a_r8_irq_from_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ev_complete);

  a_r8_data_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 2'd0 |=> !irq);

  a_r11_flag_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd1 |-> host_rdata[7] == 1'b0);

endmodule

bind xt_disk_host_if xhc_checker u_xhc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .host_rdata  (host_rdata),
  .irq         (irq),
  .status_q    (status_q),
  .state_q     (state_q),
  .sense_code  (sense_code),
  .ev_reject   (reject_now),
  .ev_cmd_ready(cmd_ready),
  .ev_rx_done  (rx_done),
  .ev_tx_done  (tx_done),
  .ev_complete (complete_q)
);

// File: tb/test_xt_disk_host_if.sv
module test_xt_disk_host_if;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int AW         = $clog2(DEPTH);
  localparam int LW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    host_addr;
  logic          host_wr, host_rd;
  logic [7:0]    host_wdata, host_rdata;
  logic          irq, dma_en, cmd_ready, drive_sel, rx_done, tx_done;
  logic [7:0]    sense_code;
  logic [LW-1:0] ex_len;
  logic          ex_rx_go, ex_tx_go, ex_done, ex_err;
  logic [7:0]    ex_sense;
  logic          ex_buf_we;
  logic [AW-1:0] ex_buf_addr;
  logic [7:0]    ex_buf_wdata, ex_buf_rdata;

  xt_disk_host_if #(.BUF_DEPTH(DEPTH)) i_xt_disk_host_if (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .dma_en(dma_en), .cmd_ready(cmd_ready), .drive_sel(drive_sel),
    .rx_done(rx_done), .tx_done(tx_done), .sense_code(sense_code),
    .ex_len(ex_len), .ex_rx_go(ex_rx_go), .ex_tx_go(ex_tx_go),
    .ex_done(ex_done), .ex_err(ex_err), .ex_sense(ex_sense),
    .ex_buf_we(ex_buf_we), .ex_buf_addr(ex_buf_addr),
    .ex_buf_wdata(ex_buf_wdata), .ex_buf_rdata(ex_buf_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } rd_item_t;
  rd_item_t rd_q[$];

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    check8(tag, {7'b0, act}, {7'b0, exp});
  endtask

  // Monitor: compares host read data against the scoreboard queue.
  always @(negedge clk) begin
    if (host_rd && !finished) begin
      if (rd_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard read with no expectation actual %02h expected none", host_rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check8(it.tag, host_rdata, it.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    tick();
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.val = exp; it.tag = tag;
    rd_q.push_back(it);
    host_addr = a; host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic ex_finish(input logic err, input logic [7:0] sense);
    ex_err = err; ex_sense = sense; ex_done = 1'b1;
    tick();
    ex_done = 1'b0; ex_err = 1'b0;
  endtask

  task automatic ex_rx(input logic [LW-1:0] n);
    ex_len = n; ex_rx_go = 1'b1;
    tick();
    ex_rx_go = 1'b0;
  endtask

  task automatic ex_tx(input logic [LW-1:0] n);
    ex_len = n; ex_tx_go = 1'b1;
    tick();
    ex_tx_go = 1'b0;
  endtask

  task automatic ex_load(input logic [AW-1:0] a, input logic [7:0] d);
    ex_buf_addr = a; ex_buf_wdata = d; ex_buf_we = 1'b1;
    tick();
    ex_buf_we = 1'b0;
  endtask

  task automatic ex_peek(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    ex_buf_addr = a;
    #1;
    check8(tag, ex_buf_rdata, exp);
  endtask

  task automatic send_block(input logic [7:0] b0, input logic [7:0] b1);
    hwrite(2'd2, 8'h00);
    hwrite(2'd0, b0);
    hwrite(2'd0, b1);
    for (int i = 2; i < 6; i++) hwrite(2'd0, 8'(i));
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; host_addr = 2'd0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
    ex_len = '0; ex_rx_go = 1'b0; ex_tx_go = 1'b0; ex_done = 1'b0; ex_err = 1'b0;
    ex_sense = 8'h00; ex_buf_we = 1'b0; ex_buf_addr = '0; ex_buf_wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state; R11 read map while idle
    check1("R1 irq after reset", irq, 1'b0);
    hread(2'd1, 8'h00, "R1 status after reset");
    hread(2'd2, 8'hFF, "R11 offset 2");
    hread(2'd3, 8'hFF, "R11 offset 3");
    hread(2'd0, 8'hFF, "R11 offset 0 idle");

    // R2 select, R3 command block to drive 1
    hwrite(2'd3, 8'h02);
    hwrite(2'd2, 8'h00);
    hread(2'd1, 8'h0D, "R2 status after select");
    hwrite(2'd0, 8'h08);
    hwrite(2'd0, 8'h20);
    for (int i = 2; i < 5; i++) hwrite(2'd0, 8'(8'h40 + i));
    check1("R3 no cmd_ready before last byte", cmd_ready, 1'b0);
    hwrite(2'd0, 8'h99);
    check1("R3 cmd_ready after sixth byte", cmd_ready, 1'b1);
    check1("R3 drive_sel from byte 1 bit 5", drive_sel, 1'b1);
    hread(2'd1, 8'h08, "R3 status after block, R11 bit 7 hidden");
    ex_peek(3'd0, 8'h08, "R3 buffer pos 0");
    ex_peek(3'd1, 8'h20, "R3 buffer pos 1");
    ex_peek(3'd4, 8'h44, "R3 buffer pos 4");
    ex_peek(3'd5, 8'h99, "R3 buffer pos 5");

    // R4 write with full buffer is rejected
    ex_load(3'd6, 8'h77);
    hwrite(2'd0, 8'h55);
    check8("R4 sense after rejected write", sense_code, 8'h20);
    ex_peek(3'd6, 8'h77, "R4 buffer untouched");

    // R5 send phase
    ex_load(3'd0, 8'hA1);
    ex_load(3'd1, 8'hB2);
    ex_load(3'd2, 8'hC3);
    ex_tx(4'd3);
    hread(2'd1, 8'h0B, "R5 status in send");
    hread(2'd0, 8'hA1, "R5 send byte 0");
    hread(2'd0, 8'hB2, "R5 send byte 1");
    check1("R5 no tx_done early", tx_done, 1'b0);
    hread(2'd0, 8'hC3, "R5 send byte 2");
    check1("R5 tx_done after last", tx_done, 1'b1);
    hread(2'd1, 8'h0A, "R5 status after send");
    hread(2'd0, 8'hFF, "R11 offset 0 while waiting");

    // R3 receive data phase
    ex_rx(4'd2);
    hread(2'd1, 8'h09, "R3 status in receive");
    hwrite(2'd0, 8'h3C);
    hwrite(2'd0, 8'h4D);
    check1("R3 rx_done after data", rx_done, 1'b1);
    check1("R3 no cmd_ready on data phase", cmd_ready, 1'b0);
    ex_peek(3'd0, 8'h3C, "R3 data pos 0");
    ex_peek(3'd1, 8'h4D, "R3 data pos 1");
    hread(2'd1, 8'h08, "R3 status after data");

    // R7 completion with rejected write pending, R8 irq, R9 completion read
    ex_finish(1'b0, 8'h00);
    check1("R8 irq at completion with mask", irq, 1'b1);
    hread(2'd1, 8'h2F, "R7 status at completion");
    check1("R8 status read keeps irq", irq, 1'b1);
    hread(2'd0, 8'h22, "R7 completion byte drive1 plus error");
    check1("R8 irq cleared by data read", irq, 1'b0);
    hread(2'd1, 8'h00, "R9 status after completion read");
    hread(2'd0, 8'hFF, "R9 idle after completion read");

    // R7 executor error, R8 no irq without mask
    hwrite(2'd3, 8'h00);
    send_block(8'h03, 8'h00);
    check1("R3 drive_sel drive 0", drive_sel, 1'b0);
    ex_finish(1'b1, 8'h04);
    check1("R8 irq masked", irq, 1'b0);
    check8("R7 sense from executor", sense_code, 8'h04);
    hread(2'd1, 8'h0F, "R7 status masked completion");
    hread(2'd0, 8'h02, "R7 completion byte error drive 0");

    // R9 clean completion, R8 offset 2 read keeps irq
    hwrite(2'd3, 8'h02);
    send_block(8'h00, 8'h00);
    ex_finish(1'b0, 8'h00);
    hread(2'd2, 8'hFF, "R11 offset 2 during completion");
    check1("R8 offset 2 read keeps irq", irq, 1'b1);
    hread(2'd0, 8'h00, "R9 clean completion byte");
    check1("R8 irq cleared", irq, 1'b0);

    // R10 host reset in mid command
    hwrite(2'd2, 8'h00);
    hwrite(2'd0, 8'h01);
    hwrite(2'd0, 8'h02);
    hwrite(2'd1, 8'h00);
    check8("R10 sense cleared", sense_code, 8'h00);
    hread(2'd1, 8'h00, "R10 status cleared");
    hread(2'd0, 8'hFF, "R10 idle after reset write");

    // R6 clamp to depth and to one
    send_block(8'h08, 8'h00);
    ex_rx(4'd15);
    for (int i = 0; i < 7; i++) hwrite(2'd0, 8'(8'h60 + i));
    check1("R6 no rx_done before depth", rx_done, 1'b0);
    hwrite(2'd0, 8'h67);
    check1("R6 rx_done at depth", rx_done, 1'b1);
    ex_peek(3'd7, 8'h67, "R6 last position");
    ex_rx(4'd0);
    hwrite(2'd0, 8'hE1);
    check1("R6 zero length acts as one", rx_done, 1'b1);
    ex_finish(1'b0, 8'h00);
    hread(2'd0, 8'h00, "R9 completion after clamp test");

    // R13 executor pulses ignored when idle
    ex_finish(1'b1, 8'h31);
    check1("R13 irq stays low", irq, 1'b0);
    check8("R13 sense unchanged", sense_code, 8'h00);
    ex_tx(4'd2);
    hread(2'd1, 8'h00, "R13 status still idle");
    hread(2'd0, 8'hFF, "R13 no send started");

    // R4 data write while idle
    hwrite(2'd0, 8'h5A);
    check8("R4 idle write rejected", sense_code, 8'h20);

    // R12 mask bit 0
    hwrite(2'd3, 8'h01);
    check1("R12 dma_en set", dma_en, 1'b1);
    hwrite(2'd3, 8'h02);
    check1("R12 dma_en clear", dma_en, 1'b0);

    tick();
    if (rd_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover actual %0d expected 0", rd_q.size());
    end
    summary();
  end

endmodule